// File: doc/BRIEF.md
# Dual-Width Peripheral-Bus Register Bank

This block is the register bank of an analog-interface controller, reached through an APB slave port. It holds one configuration register per analog input channel and one per gate-driver channel, a 15-bit interrupt status register, a 15-bit interrupt enable register, a read-only pending view and a write-only software-set register. It drives one combined interrupt line. The analog monitors, the converter and the driver circuits sit outside. They take the configuration vectors this bank drives and send it one-cycle event pulses.

A build-time parameter `WIDE` sets the data width for the whole map. With `WIDE=0` the bus carries 8 bits and each of the 32 addresses on `paddr[4:0]` is one byte register. With `WIDE=1` the bus carries 16 bits. `paddr[4:1]` then picks a pair of byte registers, with the even byte on bits [7:0] and the odd byte on bits [15:8], and `paddr[0]` is ignored. Byte map: 0 status low, 1 status high (bits 14:8), 2 enable low, 3 enable high, then two bytes per input channel from 4 upward (low byte = config bits 7:0, high byte bits 1:0 = config bits 9:8), then two bytes per gate channel, then the pending pair and the software-set pair. Every other address is reserved. With the default of four channels each, gate channels start at 12, pending is at 20/21 and software-set at 22/23.

The port has no back-pressure: `pready` is tied high, so every access completes in its first access-phase cycle, and `pslverr` is tied low.

Top module: `apb_dual_width_regbank`

## Requirements
- R1: After asynchronous active-low reset every register reads 0, both configuration vectors are 0 and `irq` is 0.
- R2: With WIDE=0, each of the 32 byte addresses reaches its own byte: a write to one address changes no other address.
- R3: With WIDE=1, `paddr[4:1]` selects a byte pair: the even byte is data bits [7:0], the odd byte bits [15:8], and `paddr[0]` has no effect on reads or writes.
- R4: A write happens only in a cycle with `psel`, `penable` and `pwrite` all high. Reads are combinational in the access phase. `pready` is always 1 and `pslverr` always 0.
- R5: Reserved bits and reserved addresses read 0: status-high bit 7, enable-high bit 7, configuration-high bits 7:2, and every address above the software-set pair.
- R6: A one-cycle pulse on `irq_evt[i]` sets status bit i. Writing 1 to a status bit clears it, and writing 0 leaves it. If a pulse and a clear meet in the same cycle, the bit stays set.
- R7: The enable register can be read and written. `irq` is high exactly when some bit i has both enable and status set.
- R8: The pending pair (addresses 20/21 by default) reads status AND enable, and writes to it change nothing.
- R9: The software-set pair (22/23 by default) reads 0, and writing 1 to a bit sets the matching status bit.
- R10: Input configuration bits [9:8] hold the usage code: 00 temperature monitor (default), 01 digital input, 10 voltage monitor, 11 disabled. All four codes are stored and appear on `ain_cfg`.
- R11: Gate configuration bits [9:8] accept 00 register control, 10 external-enable control and 11 disabled. A write of the reserved code 01 leaves those two bits unchanged, while the low byte still writes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 5 | Byte address |
| pwdata | input | 8 or 16 | Write data (16 when WIDE=1) |
| prdata | output | 8 or 16 | Read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irq_evt | input | 15 | One-cycle interrupt event pulses |
| ain_cfg | output | 10*N_IN | Input channel configurations, channel c at [10c+9:10c] |
| gd_cfg | output | 10*N_GD | Gate channel configurations, channel c at [10c+9:10c] |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench goes after the cases where the map is easy to get wrong. A wrong lane decode in word mode would put the odd byte on the low half, or let `paddr[0]` move the access. A byte decode that aliases addresses would make one write show up at two addresses. Writes made with `penable` low or `psel` low must change nothing; a design that ignored the phase would take them. A status bit that is cleared and pulsed in the same cycle must stay set; a design with the wrong priority would lose the event. Also covered: writes to the pending pair, the reserved gate code 01, and reserved bits that must read 0 after being written with ones. Each of these would show up as a read or output mismatch against the bench model.

// File: rtl/apb_bank_pkg.sv
package apb_bank_pkg;
  localparam int ADDR_W   = 5;
  localparam int NBYTES   = 1 << ADDR_W;
  localparam int NSRC     = 15;
  localparam int CFG_W    = 10;
  localparam int ST_LO    = 0;
  localparam int ST_HI    = 1;
  localparam int EN_LO    = 2;
  localparam int EN_HI    = 3;
  localparam int CFG_BASE = 4;

  typedef enum logic [1:0] {
    AIN_TEMP = 2'b00,
    AIN_DIG  = 2'b01,
    AIN_VOLT = 2'b10,
    AIN_OFF  = 2'b11
  } ain_use_e;

  typedef enum logic [1:0] {
    GD_REG  = 2'b00,
    GD_RSVD = 2'b01,
    GD_EXT  = 2'b10,
    GD_OFF  = 2'b11
  } gd_use_e;
endpackage

// File: rtl/apb_byte_decode.sv
module apb_byte_decode
  import apb_bank_pkg::*;
#(
  parameter bit WIDE = 1'b0,
  localparam int LANES = WIDE ? 2 : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          psel,
  input  logic                          penable,
  input  logic                          pwrite,
  input  logic [ADDR_W-1:0]             paddr,
  output logic [LANES-1:0][ADDR_W-1:0]  lane_addr,
  output logic [NBYTES-1:0]             byte_we
);
  // Each lane maps to one byte address; in word mode lane index is address bit 0.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (WIDE) begin : g_word
      assign lane_addr[l] = {paddr[ADDR_W-1:1], 1'(l)};
    end else begin : g_byte
      assign lane_addr[l] = paddr;
    end
  end

  always_comb begin
    byte_we = '0;
    if (psel && penable && pwrite) begin
      for (int l = 0; l < LANES; l++) byte_we[lane_addr[l]] = 1'b1;
    end
  end

  // R4: no write strobe outside a write access phase
  a_r4_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !(psel && penable && pwrite) |-> (byte_we == '0));

  // R3: every write touches exactly one byte per lane
  a_r3_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we != '0) |-> ($countones(byte_we) == LANES));
endmodule

// File: rtl/irq_core.sv
module irq_core
  import apb_bank_pkg::*;
#(
  parameter int NS = NSRC,
  localparam int HI_W = NS - 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NS-1:0]   evt,
  input  logic [NS-1:0]   clr,
  input  logic [NS-1:0]   sset,
  input  logic            en_we_lo,
  input  logic            en_we_hi,
  input  logic [7:0]      en_d_lo,
  input  logic [HI_W-1:0] en_d_hi,
  output logic [NS-1:0]   st,
  output logic [NS-1:0]   en,
  output logic            irq
);
  logic [NS-1:0] set_any;
  assign set_any = evt | sset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else begin
      st <= (st & ~clr) | set_any;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= '0;
    end else begin
      if (en_we_lo) en[7:0]    <= en_d_lo;
      if (en_we_hi) en[NS-1:8] <= en_d_hi;
    end
  end

  assign irq = |(st & en);

  // R6: a set source in the same cycle as a clear leaves the bit set
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_any != '0) |=> ((st & $past(set_any)) == $past(set_any)));

  // R6: a clear with no competing set empties the bit
  a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~set_any) != '0) |=> ((st & $past(clr & ~set_any)) == '0));

  // R6: with no clear and no set the status holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr | set_any) == '0) |=> $stable(st));

  // R7: no enable, no interrupt
  a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);
endmodule

// File: rtl/cfg_field_reg.sv
module cfg_field_reg
  import apb_bank_pkg::*;
#(
  parameter bit IS_GATE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_lo,
  input  logic             we_hi,
  input  logic [7:0]       d_lo,
  input  logic [1:0]       d_hi,
  output logic [CFG_W-1:0] q
);
  logic take_hi;

  if (IS_GATE) begin : g_gate
    assign take_hi = we_hi && (d_hi != GD_RSVD);
  end else begin : g_ain
    assign take_hi = we_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      if (we_lo)   q[7:0] <= d_lo;
      if (take_hi) q[9:8] <= d_hi;
    end
  end

  if (IS_GATE) begin : g_gate_chk
    // R11: the reserved gate code never reaches the field
    a_r11_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      q[9:8] != GD_RSVD);
  end else begin : g_ain_chk
    // R10: every usage code written is stored
    a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
      we_hi |=> (q[9:8] == $past(d_hi)));
  end
endmodule

// File: rtl/apb_dual_width_regbank.sv
module apb_dual_width_regbank
  import apb_bank_pkg::*;
#(
  parameter bit WIDE = 1'b0,
  parameter int N_IN = 4,
  parameter int N_GD = 4,
  localparam int DW = WIDE ? 16 : 8
) (
  input  logic                  pclk,
  input  logic                  presetn,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pwrite,
  input  logic [ADDR_W-1:0]     paddr,
  input  logic [DW-1:0]         pwdata,
  output logic [DW-1:0]         prdata,
  output logic                  pready,
  output logic                  pslverr,
  input  logic [NSRC-1:0]       irq_evt,
  output logic [CFG_W*N_IN-1:0] ain_cfg,
  output logic [CFG_W*N_GD-1:0] gd_cfg,
  output logic                  irq
);
  localparam int LANES   = WIDE ? 2 : 1;
  localparam int HI_W    = NSRC - 8;
  localparam int GD_BASE = CFG_BASE + 2 * N_IN;
  localparam int PEND_LO = GD_BASE + 2 * N_GD;
  localparam int SSET_LO = PEND_LO + 2;
  localparam int LAST    = SSET_LO + 1;

  logic [LANES-1:0][ADDR_W-1:0] laddr;
  logic [NBYTES-1:0]            bwe;
  logic [7:0]                   wev, wod;
  logic [NSRC-1:0]              clr, sset, st, en, pend;
  logic [7:0]                   rb [NBYTES];

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  apb_byte_decode #(.WIDE(WIDE)) u_dec (
    .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .lane_addr(laddr), .byte_we(bwe)
  );

  // even addresses always use the low lane; odd use the high lane in word mode
  assign wev = pwdata[7:0];
  if (WIDE) begin : g_wod_w
    assign wod = pwdata[DW-1:8];
  end else begin : g_wod_b
    assign wod = pwdata[7:0];
  end

  assign clr  = {bwe[ST_HI] ? wod[HI_W-1:0] : {HI_W{1'b0}},
                 bwe[ST_LO] ? wev : 8'h00};
  assign sset = {bwe[SSET_LO+1] ? wod[HI_W-1:0] : {HI_W{1'b0}},
                 bwe[SSET_LO] ? wev : 8'h00};

  irq_core #(.NS(NSRC)) u_irq (
    .clk(pclk), .rst_n(presetn), .evt(irq_evt), .clr(clr), .sset(sset),
    .en_we_lo(bwe[EN_LO]), .en_we_hi(bwe[EN_HI]),
    .en_d_lo(wev), .en_d_hi(wod[HI_W-1:0]),
    .st(st), .en(en), .irq(irq)
  );

  for (genvar c = 0; c < N_IN; c++) begin : g_ain
    cfg_field_reg #(.IS_GATE(1'b0)) u_cfg (
      .clk(pclk), .rst_n(presetn),
      .we_lo(bwe[CFG_BASE+2*c]), .we_hi(bwe[CFG_BASE+2*c+1]),
      .d_lo(wev), .d_hi(wod[1:0]), .q(ain_cfg[CFG_W*c +: CFG_W])
    );
  end

  for (genvar c = 0; c < N_GD; c++) begin : g_gd
    cfg_field_reg #(.IS_GATE(1'b1)) u_cfg (
      .clk(pclk), .rst_n(presetn),
      .we_lo(bwe[GD_BASE+2*c]), .we_hi(bwe[GD_BASE+2*c+1]),
      .d_lo(wev), .d_hi(wod[1:0]), .q(gd_cfg[CFG_W*c +: CFG_W])
    );
  end

  assign pend = st & en;

  always_comb begin
    for (int i = 0; i < NBYTES; i++) rb[i] = 8'h00;
    rb[ST_LO] = st[7:0];
    rb[ST_HI] = {1'b0, st[NSRC-1:8]};
    rb[EN_LO] = en[7:0];
    rb[EN_HI] = {1'b0, en[NSRC-1:8]};
    for (int c = 0; c < N_IN; c++) begin
      rb[CFG_BASE+2*c]   = ain_cfg[CFG_W*c +: 8];
      rb[CFG_BASE+2*c+1] = {6'b0, ain_cfg[CFG_W*c+8 +: 2]};
    end
    for (int c = 0; c < N_GD; c++) begin
      rb[GD_BASE+2*c]    = gd_cfg[CFG_W*c +: 8];
      rb[GD_BASE+2*c+1]  = {6'b0, gd_cfg[CFG_W*c+8 +: 2]};
    end
    rb[PEND_LO]   = pend[7:0];
    rb[PEND_LO+1] = {1'b0, pend[NSRC-1:8]};
  end

  for (genvar l = 0; l < LANES; l++) begin : g_rd
    assign prdata[8*l +: 8] = rb[laddr[l]];
  end

  // R5: addresses past the last mapped pair return zero
  a_r5_unmapped: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && ({paddr[ADDR_W-1:1], 1'b0} > LAST)) |-> (prdata == '0));

  // R8: a write aimed only at the pending pair disturbs no status bit
  a_r8_pend_ro: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pwrite && (paddr[ADDR_W-1:1] == PEND_LO[ADDR_W-1:1])
     && (irq_evt == '0)) |=> $stable(u_irq.st));
endmodule

// File: tb/tb_apb_dual_width_regbank.sv
module tb_apb_dual_width_regbank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        psel [2];
  logic        penable [2];
  logic        pwrite [2];
  logic [4:0]  paddr [2];
  logic [15:0] pwdata [2];
  logic [7:0]  prd0;
  logic [15:0] prd1;
  logic        rdy0, rdy1, err0, err1, irq0, irq1;
  logic [14:0] evt = '0;
  logic [39:0] ain0, ain1, gd0, gd1;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  apb_dual_width_regbank #(.WIDE(1'b0)) dut (
    .pclk(clk), .presetn(rst_n), .psel(psel[0]), .penable(penable[0]),
    .pwrite(pwrite[0]), .paddr(paddr[0]), .pwdata(pwdata[0][7:0]),
    .prdata(prd0), .pready(rdy0), .pslverr(err0), .irq_evt(evt),
    .ain_cfg(ain0), .gd_cfg(gd0), .irq(irq0));

  apb_dual_width_regbank #(.WIDE(1'b1)) dut_w (
    .pclk(clk), .presetn(rst_n), .psel(psel[1]), .penable(penable[1]),
    .pwrite(pwrite[1]), .paddr(paddr[1]), .pwdata(pwdata[1]),
    .prdata(prd1), .pready(rdy1), .pslverr(err1), .irq_evt(evt),
    .ain_cfg(ain1), .gd_cfg(gd1), .irq(irq1));

  // bench model
  logic [14:0] m_st [2];
  logic [14:0] m_en [2];
  logic [9:0]  m_ain [2][4];
  logic [9:0]  m_gd [2][4];

  task automatic chk(bit ok, string tag, logic [39:0] act, logic [39:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int k, int a);
    logic [14:0] p;
    p = m_st[k] & m_en[k];
    if (a == 0) return m_st[k][7:0];
    if (a == 1) return {1'b0, m_st[k][14:8]};
    if (a == 2) return m_en[k][7:0];
    if (a == 3) return {1'b0, m_en[k][14:8]};
    if (a >= 4 && a < 12)
      return (a % 2 == 0) ? m_ain[k][(a-4)/2][7:0] : {6'b0, m_ain[k][(a-4)/2][9:8]};
    if (a >= 12 && a < 20)
      return (a % 2 == 0) ? m_gd[k][(a-12)/2][7:0] : {6'b0, m_gd[k][(a-12)/2][9:8]};
    if (a == 20) return p[7:0];
    if (a == 21) return {1'b0, p[14:8]};
    return 8'h00;
  endfunction

  function automatic logic [15:0] exp_read(int k, logic [4:0] a);
    if (k == 1) return {exp_byte(1, {27'd0, a[4:1], 1'b1}), exp_byte(1, {27'd0, a[4:1], 1'b0})};
    return {8'h00, exp_byte(0, {27'd0, a})};
  endfunction

  task automatic commit(int k, bit wr, logic [4:0] addr, logic [15:0] data, logic [14:0] ev);
    logic [14:0] clr, set;
    clr = '0;
    set = '0;
    if (wr) begin
      for (int l = 0; l < (k == 1 ? 2 : 1); l++) begin
        int a;
        logic [7:0] b;
        a = (k == 1) ? {27'd0, addr[4:1], l[0]} : {27'd0, addr};
        b = data[8*l +: 8];
        if (a == 0) clr[7:0] = b;
        else if (a == 1) clr[14:8] = b[6:0];
        else if (a == 2) m_en[k][7:0] = b;
        else if (a == 3) m_en[k][14:8] = b[6:0];
        else if (a >= 4 && a < 12) begin
          if (a % 2 == 0) m_ain[k][(a-4)/2][7:0] = b;
          else m_ain[k][(a-4)/2][9:8] = b[1:0];
        end else if (a >= 12 && a < 20) begin
          if (a % 2 == 0) m_gd[k][(a-12)/2][7:0] = b;
          else if (b[1:0] != 2'b01) m_gd[k][(a-12)/2][9:8] = b[1:0];
        end else if (a == 22) set[7:0] = b;
        else if (a == 23) set[14:8] = b[6:0];
      end
    end
    for (int j = 0; j < 2; j++)
      m_st[j] = (m_st[j] & ~((j == k) ? clr : 15'd0)) | ev | ((j == k) ? set : 15'd0);
  endtask

  task automatic xfer(int k, bit wr, logic [4:0] a, logic [15:0] d, logic [14:0] ev,
                      output logic [15:0] rd);
    @(negedge clk);
    psel[k] = 1'b1; pwrite[k] = wr; paddr[k] = a; pwdata[k] = d; penable[k] = 1'b0;
    @(negedge clk);
    penable[k] = 1'b1; evt = ev;
    #1;
    rd = (k == 1) ? prd1 : {8'h00, prd0};
    chk(((k == 1) ? rdy1 : rdy0) && !((k == 1) ? err1 : err0), "R4 pready/pslverr",
        {38'd0, (k == 1) ? rdy1 : rdy0, (k == 1) ? err1 : err0}, 40'h2);
    @(posedge clk);
    commit(k, wr, a, d, ev);
    @(negedge clk);
    psel[k] = 1'b0; penable[k] = 1'b0; pwrite[k] = 1'b0; evt = '0;
  endtask

  task automatic wr(int k, logic [4:0] a, logic [15:0] d);
    logic [15:0] rd;
    xfer(k, 1'b1, a, d, 15'd0, rd);
  endtask

  task automatic rd_chk(int k, logic [4:0] a, string tag);
    logic [15:0] exp, rd;
    exp = exp_read(k, a);
    xfer(k, 1'b0, a, 16'h0, 15'd0, rd);
    chk(rd == exp, tag, {24'd0, rd}, {24'd0, exp});
  endtask

  task automatic outs_chk(string tag);
    logic [39:0] ea0, ea1, eg0, eg1;
    for (int c = 0; c < 4; c++) begin
      ea0[10*c +: 10] = m_ain[0][c]; ea1[10*c +: 10] = m_ain[1][c];
      eg0[10*c +: 10] = m_gd[0][c];  eg1[10*c +: 10] = m_gd[1][c];
    end
    chk(ain0 == ea0 && ain1 == ea1, {tag, " ain_cfg"}, ain0 ^ ain1, ea0 ^ ea1);
    chk(gd0 == eg0 && gd1 == eg1, {tag, " gd_cfg"}, gd0 ^ gd1, eg0 ^ eg1);
    chk(irq0 == |(m_st[0] & m_en[0]) && irq1 == |(m_st[1] & m_en[1]), {tag, " irq R7"},
        {38'd0, irq0, irq1}, {38'd0, |(m_st[0] & m_en[0]), |(m_st[1] & m_en[1])});
  endtask

  task automatic pulse(logic [14:0] m);
    @(negedge clk); evt = m;
    @(posedge clk); commit(0, 1'b0, 5'd0, 16'd0, m);
    @(negedge clk); evt = '0;
  endtask

  task automatic ghost(int k, logic [4:0] a, logic [15:0] d);
    @(negedge clk); psel[k] = 1'b1; pwrite[k] = 1'b1; penable[k] = 1'b0; paddr[k] = a; pwdata[k] = d;
    @(negedge clk); psel[k] = 1'b0; penable[k] = 1'b1;
    @(negedge clk); penable[k] = 1'b0; pwrite[k] = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 2; k++) begin
      psel[k] = 0; penable[k] = 0; pwrite[k] = 0; paddr[k] = 0; pwdata[k] = 0;
      m_st[k] = 0; m_en[k] = 0;
      for (int c = 0; c < 4; c++) begin m_ain[k][c] = 0; m_gd[k][c] = 0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state everywhere
    for (int a = 0; a < 32; a++) rd_chk(0, 5'(a), "R1 byte reset");
    for (int a = 0; a < 32; a += 2) rd_chk(1, 5'(a), "R1 word reset");
    outs_chk("R1");

    // R2: distinct byte registers
    wr(0, 5'h04, 16'h00A5); wr(0, 5'h05, 16'h0002); wr(0, 5'h06, 16'h003C);
    chk(ain0[9:0] == 10'h2A5, "R2 ain0 ch0", {30'd0, ain0[9:0]}, 40'h2A5);
    for (int a = 0; a < 32; a++) rd_chk(0, 5'(a), "R2 byte map");

    // R10: all usage codes stored
    for (int c = 0; c < 4; c++) begin
      wr(0, 5'h07, 16'(c));
      chk(ain0[19:18] == 2'(c), "R10 usage code", {38'd0, ain0[19:18]}, 40'(c));
    end

    // R5: reserved bits and addresses
    wr(0, 5'h05, 16'h00FF); rd_chk(0, 5'h05, "R5 cfg high reserved");
    wr(0, 5'h1A, 16'h00FF); rd_chk(0, 5'h1A, "R5 unmapped");
    wr(0, 5'h03, 16'h00FF); rd_chk(0, 5'h03, "R5 enable bit7");
    wr(0, 5'h03, 16'h0000);

    // R3: odd word address, halves
    wr(1, 5'h09, 16'h01C3);
    chk(ain1[29:20] == 10'h1C3, "R3 word halves", {30'd0, ain1[29:20]}, 40'h1C3);
    rd_chk(1, 5'h08, "R3 even addr read");
    rd_chk(1, 5'h09, "R3 odd addr read");

    // R4: non-access cycles write nothing
    ghost(0, 5'h02, 16'h00FF); ghost(1, 5'h02, 16'hFFFF);
    rd_chk(0, 5'h02, "R4 ghost byte"); rd_chk(1, 5'h02, "R4 ghost word");

    // R7/R6: enable, event, clear, set wins
    wr(0, 5'h02, 16'h0001);
    pulse(15'h0001); outs_chk("R6 event sets");
    wr(0, 5'h00, 16'h0001); outs_chk("R6 w1c clears");
    begin
      logic [15:0] rd;
      xfer(0, 1'b1, 5'h00, 16'h0001, 15'h0001, rd);
    end
    rd_chk(0, 5'h00, "R6 set wins");
    outs_chk("R6 set wins");

    // R8: pending read-only
    wr(0, 5'h14, 16'h0000); rd_chk(0, 5'h14, "R8 pending"); rd_chk(0, 5'h00, "R8 status kept");

    // R9: software set
    wr(0, 5'h17, 16'h0040); rd_chk(0, 5'h17, "R9 reads zero"); rd_chk(0, 5'h01, "R9 sets status");
    wr(1, 5'h16, 16'h4001); rd_chk(1, 5'h00, "R9 word set");

    // R11: reserved gate code
    wr(0, 5'h0D, 16'h0002); wr(0, 5'h0D, 16'h0001);
    chk(gd0[9:8] == 2'b10, "R11 reserved ignored", {38'd0, gd0[9:8]}, 40'h2);
    wr(0, 5'h0D, 16'h0003); rd_chk(0, 5'h0D, "R11 disabled code");
    wr(1, 5'h0C, 16'h0155); rd_chk(1, 5'h0C, "R11 word low byte with 01");

    // random mix, R2 R3 R6 R7 R11 against the model
    for (int i = 0; i < 800; i++) begin
      int k, op;
      logic [4:0] a;
      logic [15:0] d;
      k = $urandom % 2; op = $urandom % 5;
      a = 5'($urandom); d = 16'($urandom);
      case (op)
        0, 1: wr(k, a, d);
        2: rd_chk(k, a, "R2/R3 random read");
        3: pulse(15'($urandom) & 15'($urandom));
        default: ghost(k, a, d);
      endcase
      if (i % 8 == 0) outs_chk("R6/R7/R11 random");
    end
    outs_chk("final");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule